// File: doc/BRIEF.md
# Jump, Branch and Relative-Load Control Decoder

This block is the control decoder for the program-flow and load instructions of a simple single-cycle processor. It reads the 6-bit opcode of the current instruction and the zero flag. The zero flag is 1 when the first source register reads as all zeros. From these two inputs it drives the datapath select and enable lines. The block is purely combinational, so its outputs follow its inputs within the same cycle.

Five instruction classes are decoded:

- **Register jump:** takes the next PC from the first source register.
- **Branch if zero / branch if non-zero:** pick between the offset-adder target and the incremented PC, using the zero flag.
- **Absolute load:** adds the register to the literal to form the address.
- **PC-relative load:** sends the offset-adder target through the A-operand select and an ALU pass-through, so the address timing matches that of the normal load.

Every class writes back into the destination register. Every selector the instruction does not use is driven to zero, and the memory write enable is never left floating. Each opcode value is a parameter of the design.

Top module: `jbl_ctrl_decode`

## Requirements
- R1: For the jump opcode, pc_sel_o is 2 (register target), wd_sel_o is 0 (incremented PC) and rf_we_o is 1, for either value of zero_i.
- R2: For branch-if-zero, pc_sel_o is 1 (offset target) when zero_i is 1 and 0 (incremented PC) when zero_i is 0. wd_sel_o is 0 and rf_we_o is 1.
- R3: For branch-if-non-zero, pc_sel_o is 1 when zero_i is 0 and 0 when zero_i is 1. wd_sel_o is 0 and rf_we_o is 1.
- R4: For the relative load:
  - a_sel_o is 1 (offset target as the A operand) and alu_fn_o is FN_PASSA (default 4'hA).
  - wd_sel_o is 2 (memory data), rf_we_o is 1 and pc_sel_o is 0.
  - These values hold for either value of zero_i.
- R5: For the absolute load:
  - a_sel_o is 0 (register operand), b_sel_o is 1 (literal) and alu_fn_o is FN_ADD (default 4'h1).
  - wd_sel_o is 2, rf_we_o is 1 and pc_sel_o is 0.
  - These values hold for either value of zero_i.
- R6: mem_we_o is 0 for every opcode and every zero_i value.
- R7: Any opcode that matches none of the five parameters drives rf_we_o 0 and pc_sel_o 0.
- R8: For jump, both branches and unrecognised opcodes, a_sel_o and b_sel_o are 0 and alu_fn_o is FN_IDLE (default 4'h0). For unrecognised opcodes, wd_sel_o is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | OPC_W (6) | Opcode field of the current instruction |
| zero_i | input | 1 | 1 when the first source register is all zeros |
| pc_sel_o | output | 3 | Next-PC source: 0 incremented PC, 1 offset target, 2 register |
| a_sel_o | output | 1 | A-operand source: 0 register, 1 offset target |
| b_sel_o | output | 1 | B-operand source: 0 register, 1 sign-extended literal |
| wd_sel_o | output | 2 | Write-back source: 0 incremented PC, 1 ALU, 2 memory |
| alu_fn_o | output | FN_W (4) | ALU function code |
| rf_we_o | output | 1 | Register-file write enable |
| mem_we_o | output | 1 | Memory write enable |

## Verification
The bench drives every supported opcode with both zero-flag values. The two branch kinds are the sharpest corner: a decoder with their senses swapped would jump on exactly the cases that should fall through. The relative load is checked for both the pass-through function and the A-select. A design that reused the add code, or left the register as the A operand, would fetch from a wrong address. Random opcodes outside the decoded set confirm that no stray register write, PC redirect or memory write occurs, and that unused selectors stay at zero rather than leaking another class's settings.

// File: rtl/jbl_ctrl_pkg.sv
package jbl_ctrl_pkg;

    typedef enum logic [2:0] {
        PCS_INC    = 3'd0,
        PCS_BRANCH = 3'd1,
        PCS_REG    = 3'd2
    } pc_src_e;

    typedef enum logic [1:0] {
        WDS_PCINC = 2'd0,
        WDS_ALU   = 2'd1,
        WDS_MEM   = 2'd2
    } wd_src_e;

    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_JMP  = 3'd1,
        CLS_BEQ  = 3'd2,
        CLS_BNE  = 3'd3,
        CLS_LD   = 3'd4,
        CLS_LDR  = 3'd5
    } op_class_e;

    localparam int NUM_CLASSES = 5;

    typedef struct packed {
        logic    a_sel;
        logic    b_sel;
        wd_src_e wd_sel;
        logic    rf_we;
        logic    mem_we;
    } dp_ctrl_t;

endpackage

// File: rtl/jbl_op_classify.sv
module jbl_op_classify
    import jbl_ctrl_pkg::*;
#(
    parameter int                OPC_W   = 6,
    parameter logic [OPC_W-1:0]  OPC_JMP = 6'h1B,
    parameter logic [OPC_W-1:0]  OPC_BEQ = 6'h1C,
    parameter logic [OPC_W-1:0]  OPC_BNE = 6'h1D,
    parameter logic [OPC_W-1:0]  OPC_LD  = 6'h18,
    parameter logic [OPC_W-1:0]  OPC_LDR = 6'h1F
) (
    input  logic [OPC_W-1:0] opcode_i,
    output op_class_e        class_o
);

    // Index k of this table maps to class value k+1.
    localparam logic [OPC_W-1:0] MATCH_TBL [NUM_CLASSES] =
        '{OPC_JMP, OPC_BEQ, OPC_BNE, OPC_LD, OPC_LDR};

    logic [NUM_CLASSES-1:0] hit;

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_match
        assign hit[g] = (opcode_i == MATCH_TBL[g]);
    end

    always_comb begin
        class_o = CLS_NONE;
        for (int k = 0; k < NUM_CLASSES; k++) begin
            if (hit[k]) class_o = op_class_e'(3'(k + 1));
        end
    end

endmodule

// File: rtl/jbl_pc_select.sv
module jbl_pc_select
    import jbl_ctrl_pkg::*;
(
    input  op_class_e class_i,
    input  logic      zero_i,
    output pc_src_e   pc_sel_o
);

    always_comb begin
        unique case (class_i)
            CLS_JMP: pc_sel_o = PCS_REG;
            CLS_BEQ: pc_sel_o = zero_i ? PCS_BRANCH : PCS_INC;
            CLS_BNE: pc_sel_o = zero_i ? PCS_INC : PCS_BRANCH;
            default: pc_sel_o = PCS_INC;
        endcase
    end

endmodule

// File: rtl/jbl_dp_select.sv
module jbl_dp_select
    import jbl_ctrl_pkg::*;
#(
    parameter int              FN_W     = 4,
    parameter logic [FN_W-1:0] FN_IDLE  = 4'h0,
    parameter logic [FN_W-1:0] FN_ADD   = 4'h1,
    parameter logic [FN_W-1:0] FN_PASSA = 4'hA
) (
    input  op_class_e       class_i,
    output dp_ctrl_t        ctrl_o,
    output logic [FN_W-1:0] alu_fn_o
);

    always_comb begin
        ctrl_o   = '0;
        alu_fn_o = FN_IDLE;
        unique case (class_i)
            CLS_JMP, CLS_BEQ, CLS_BNE: begin
                ctrl_o.wd_sel = WDS_PCINC;
                ctrl_o.rf_we  = 1'b1;
            end
            CLS_LD: begin
                ctrl_o.b_sel  = 1'b1;
                ctrl_o.wd_sel = WDS_MEM;
                ctrl_o.rf_we  = 1'b1;
                alu_fn_o      = FN_ADD;
            end
            CLS_LDR: begin
                ctrl_o.a_sel  = 1'b1;
                ctrl_o.wd_sel = WDS_MEM;
                ctrl_o.rf_we  = 1'b1;
                alu_fn_o      = FN_PASSA;
            end
            default: begin
                ctrl_o   = '0;
                alu_fn_o = FN_IDLE;
            end
        endcase
        ctrl_o.mem_we = 1'b0;
    end

endmodule

// File: rtl/jbl_ctrl_decode.sv
module jbl_ctrl_decode
    import jbl_ctrl_pkg::*;
#(
    parameter int                OPC_W    = 6,
    parameter logic [OPC_W-1:0]  OPC_JMP  = 6'h1B,
    parameter logic [OPC_W-1:0]  OPC_BEQ  = 6'h1C,
    parameter logic [OPC_W-1:0]  OPC_BNE  = 6'h1D,
    parameter logic [OPC_W-1:0]  OPC_LD   = 6'h18,
    parameter logic [OPC_W-1:0]  OPC_LDR  = 6'h1F,
    parameter int                FN_W     = 4,
    parameter logic [FN_W-1:0]   FN_IDLE  = 4'h0,
    parameter logic [FN_W-1:0]   FN_ADD   = 4'h1,
    parameter logic [FN_W-1:0]   FN_PASSA = 4'hA
) (
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             zero_i,
    output logic [2:0]       pc_sel_o,
    output logic             a_sel_o,
    output logic             b_sel_o,
    output logic [1:0]       wd_sel_o,
    output logic [FN_W-1:0]  alu_fn_o,
    output logic             rf_we_o,
    output logic             mem_we_o
);

    op_class_e       op_class;
    pc_src_e         pc_src;
    dp_ctrl_t        dp_ctrl;
    logic [FN_W-1:0] dp_fn;

    jbl_op_classify #(
        .OPC_W  (OPC_W),
        .OPC_JMP(OPC_JMP),
        .OPC_BEQ(OPC_BEQ),
        .OPC_BNE(OPC_BNE),
        .OPC_LD (OPC_LD),
        .OPC_LDR(OPC_LDR)
    ) u_classify (
        .opcode_i(opcode_i),
        .class_o (op_class)
    );

    jbl_pc_select u_pc_select (
        .class_i (op_class),
        .zero_i  (zero_i),
        .pc_sel_o(pc_src)
    );

    jbl_dp_select #(
        .FN_W    (FN_W),
        .FN_IDLE (FN_IDLE),
        .FN_ADD  (FN_ADD),
        .FN_PASSA(FN_PASSA)
    ) u_dp_select (
        .class_i (op_class),
        .ctrl_o  (dp_ctrl),
        .alu_fn_o(dp_fn)
    );

    dp_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d        = dp_ctrl;
        ctrl_d.mem_we = 1'b0;
    end

    assign pc_sel_o = pc_src;
    assign a_sel_o  = ctrl_d.a_sel;
    assign b_sel_o  = ctrl_d.b_sel;
    assign wd_sel_o = ctrl_d.wd_sel;
    assign alu_fn_o = dp_fn;
    assign rf_we_o  = ctrl_d.rf_we;
    assign mem_we_o = ctrl_d.mem_we;

endmodule

// File: rtl/jbl_ctrl_decode_chk.sv
module jbl_ctrl_decode_chk #(
    parameter int                OPC_W    = 6,
    parameter logic [OPC_W-1:0]  OPC_JMP  = 6'h1B,
    parameter logic [OPC_W-1:0]  OPC_BEQ  = 6'h1C,
    parameter logic [OPC_W-1:0]  OPC_BNE  = 6'h1D,
    parameter logic [OPC_W-1:0]  OPC_LD   = 6'h18,
    parameter logic [OPC_W-1:0]  OPC_LDR  = 6'h1F,
    parameter int                FN_W     = 4,
    parameter logic [FN_W-1:0]   FN_PASSA = 4'hA
) (
    input logic [OPC_W-1:0] opcode_i,
    input logic             zero_i,
    input logic [2:0]       pc_sel_o,
    input logic             a_sel_o,
    input logic [1:0]       wd_sel_o,
    input logic [FN_W-1:0]  alu_fn_o,
    input logic             rf_we_o,
    input logic             mem_we_o
);

    logic known;
    logic recognised;

    always_comb begin
        known      = !$isunknown({opcode_i, zero_i});
        recognised = (opcode_i == OPC_JMP) || (opcode_i == OPC_BEQ) ||
                     (opcode_i == OPC_BNE) || (opcode_i == OPC_LD)  ||
                     (opcode_i == OPC_LDR);
        if (known) begin
            // R6
            mem_we_low_chk: assert (mem_we_o == 1'b0)
                else $error("memory write enable raised");
            if (opcode_i == OPC_JMP) begin
                // R1
                jmp_reg_target_chk: assert (pc_sel_o == 3'd2 && rf_we_o && wd_sel_o == 2'd0)
                    else $error("jump controls wrong");
            end
            if (opcode_i == OPC_BEQ) begin
                // R2
                beq_sense_chk: assert (pc_sel_o == (zero_i ? 3'd1 : 3'd0))
                    else $error("branch-if-zero direction wrong");
            end
            if (opcode_i == OPC_BNE) begin
                // R3
                bne_sense_chk: assert (pc_sel_o == (zero_i ? 3'd0 : 3'd1))
                    else $error("branch-if-non-zero direction wrong");
            end
            if (opcode_i == OPC_LDR) begin
                // R4
                ldr_route_chk: assert (a_sel_o && alu_fn_o == FN_PASSA &&
                                       wd_sel_o == 2'd2 && pc_sel_o == 3'd0)
                    else $error("relative load routing wrong");
            end
            if (!recognised) begin
                // R7
                unknown_quiet_chk: assert (!rf_we_o && pc_sel_o == 3'd0)
                    else $error("unrecognised opcode not quiet");
            end
        end
    end

endmodule

bind jbl_ctrl_decode jbl_ctrl_decode_chk #(
    .OPC_W   (OPC_W),
    .OPC_JMP (OPC_JMP),
    .OPC_BEQ (OPC_BEQ),
    .OPC_BNE (OPC_BNE),
    .OPC_LD  (OPC_LD),
    .OPC_LDR (OPC_LDR),
    .FN_W    (FN_W),
    .FN_PASSA(FN_PASSA)
) u_chk (
    .opcode_i(opcode_i),
    .zero_i  (zero_i),
    .pc_sel_o(pc_sel_o),
    .a_sel_o (a_sel_o),
    .wd_sel_o(wd_sel_o),
    .alu_fn_o(alu_fn_o),
    .rf_we_o (rf_we_o),
    .mem_we_o(mem_we_o)
);

// File: tb/jbl_ctrl_decode_test.sv
module jbl_ctrl_decode_test;

    localparam logic [5:0] T_JMP = 6'h1B;
    localparam logic [5:0] T_BEQ = 6'h1C;
    localparam logic [5:0] T_BNE = 6'h1D;
    localparam logic [5:0] T_LD  = 6'h18;
    localparam logic [5:0] T_LDR = 6'h1F;

    typedef struct packed {
        logic [2:0] pc;
        logic       a;
        logic       b;
        logic [1:0] wd;
        logic [3:0] fn;
        logic       we;
        logic       mw;
    } ctl_t;

    logic       clk = 1'b0;
    logic [5:0] opcode;
    logic       zero;
    logic [2:0] pc_sel;
    logic       a_sel, b_sel, rf_we, mem_we;
    logic [1:0] wd_sel;
    logic [3:0] alu_fn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    jbl_ctrl_decode uut (
        .opcode_i(opcode),
        .zero_i  (zero),
        .pc_sel_o(pc_sel),
        .a_sel_o (a_sel),
        .b_sel_o (b_sel),
        .wd_sel_o(wd_sel),
        .alu_fn_o(alu_fn),
        .rf_we_o (rf_we),
        .mem_we_o(mem_we)
    );

    function automatic ctl_t expect_ctl(logic [5:0] op, logic z);
        ctl_t e = '0;
        case (op)
            T_JMP: begin e.pc = 3'd2; e.we = 1'b1; end
            T_BEQ: begin e.pc = z ? 3'd1 : 3'd0; e.we = 1'b1; end
            T_BNE: begin e.pc = z ? 3'd0 : 3'd1; e.we = 1'b1; end
            T_LD:  begin e.b = 1'b1; e.fn = 4'h1; e.wd = 2'd2; e.we = 1'b1; end
            T_LDR: begin e.a = 1'b1; e.fn = 4'hA; e.wd = 2'd2; e.we = 1'b1; end
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic string req_of(logic [5:0] op);
        case (op)
            T_JMP:   return "R1";
            T_BEQ:   return "R2";
            T_BNE:   return "R3";
            T_LDR:   return "R4";
            T_LD:    return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic apply_and_check(logic [5:0] op, logic z);
        ctl_t got, exp;
        @(negedge clk);
        opcode = op;
        zero   = z;
        #2;
        got = {pc_sel, a_sel, b_sel, wd_sel, alu_fn, rf_we, mem_we};
        exp = expect_ctl(op, z);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%h z=%0b got=%h exp=%h", req_of(op), op, z, got, exp);
        end
        checks++;
        if (mem_we !== 1'b0) begin // R6
            errors++;
            $display("FAIL R6 op=%h z=%0b got=%b exp=0", op, z, mem_we);
        end
        if (op != T_LD && op != T_LDR) begin
            checks++;
            if ({a_sel, b_sel, alu_fn} !== 6'b0) begin // R8
                errors++;
                $display("FAIL R8 op=%h z=%0b got=%h exp=0", op, z, {a_sel, b_sel, alu_fn});
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [5];
        ops = '{T_JMP, T_BEQ, T_BNE, T_LD, T_LDR};
        void'($urandom(32'd20240611));
        opcode = 6'h00;
        zero   = 1'b0;
        // default state on an unrecognised opcode (R7)
        apply_and_check(6'h00, 1'b0);
        // directed: every supported opcode under both flag values (R1..R5)
        for (int i = 0; i < 5; i++) begin
            apply_and_check(ops[i], 1'b0);
            apply_and_check(ops[i], 1'b1);
        end
        // directed: neighbours of the decoded opcodes and extremes (R7, R8)
        apply_and_check(6'h3F, 1'b1);
        apply_and_check(6'h1A, 1'b1);
        apply_and_check(6'h1E, 1'b0);
        apply_and_check(6'h19, 1'b1);
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [5:0] op;
            if ($urandom_range(0, 1) == 0) op = ops[$urandom_range(0, 4)];
            else                           op = 6'($urandom_range(0, 63));
            apply_and_check(op, 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule